// File: doc/BRIEF.md
# Message Buffer Interrupt Flag Unit

This block keeps one interrupt flag per message buffer of a CAN-style controller, plus one flag for each of five controller status events (bus off, error, transmit warning, receive warning, wake-up). Single-cycle set pulses from the buffer engine, the receive FIFO and the status logic raise the flags. A small register port lets a CPU read the flags, clear chosen flags and program the masks. Every flag has a registered interrupt line gated by its mask. A combined line goes high when any enabled buffer source is pending.

When FIFO mode is switched on, the low byte of the buffer flag register takes on a new meaning. Three of its bits report FIFO overflow, FIFO warning and frames available. The remaining low bits are held at zero. Buffer set pulses for that byte are then ignored. Clearing works one bit at a time with write-one-to-clear, so a flag that rises while the CPU is servicing another one is never lost.

Top module: `mb_irq_unit`

## Requirements
- R1: After reset every flag, every mask, the mode bit, all interrupt outputs and the read data are zero.
- R2: A one-cycle pulse on `buf_set[i]` sets buffer flag i, which reads back at register address 0, bit i (outside the FIFO-remapped byte when FIFO mode is on).
- R3: A write to address 0 clears exactly the flag bits written as 1. Bits written as 0 keep their value.
- R4: When a set pulse and a clearing write target the same flag in the same cycle, the flag ends up set.
- R5: Each `buf_irq[i]` is the registered AND of buffer flag i and mask bit i, where address 1 holds the buffer masks. It follows its flag and mask one cycle later.
- R6: `buf_irq_any` is high exactly when at least one buffer line is high, and it follows one cycle after the flags and masks.
- R7: With FIFO mode on (address 3, bit 0 = 1), flag bit 7 is set by `fifo_ovf`, bit 6 by `fifo_warn` and bit 5 by `fifo_avail`.
- R8: With FIFO mode on, flag bits 4 to 0 read zero, and buffer set pulses for bits 7 to 0 are ignored. With FIFO mode off, the three FIFO event inputs are ignored.
- R9: Address 4 holds five write-one-to-clear status flags: bit 0 bus off, 1 error, 2 transmit warning, 3 receive warning, 4 wake-up. Address 2 bits 3 to 0 mask the first four, and address 3 bit 1 masks wake-up. `stat_irq[k]` is the registered AND of status flag k and its mask.
- R10: Reads return data one cycle after `reg_rd`. Unmapped addresses (5 to 7) read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| buf_set | input | NUM_BUF | Per-buffer flag set pulses |
| fifo_ovf | input | 1 | FIFO overflow event pulse |
| fifo_warn | input | 1 | FIFO warning event pulse |
| fifo_avail | input | 1 | FIFO frames-available event pulse |
| ev_busoff | input | 1 | Bus-off event pulse |
| ev_err | input | 1 | Error event pulse |
| ev_txwarn | input | 1 | Transmit warning event pulse |
| ev_rxwarn | input | 1 | Receive warning event pulse |
| ev_wake | input | 1 | Wake-up event pulse |
| buf_irq | output | NUM_BUF | Per-buffer masked interrupt lines |
| buf_irq_any | output | 1 | OR of all enabled buffer sources |
| stat_irq | output | 5 | Masked status interrupt lines |

## Verification
The clear-side property only applies in cycles with no concurrent set pulse and with FIFO mode off. This lets it isolate write-one-to-clear from set priority and from low-byte zeroing. The set-priority property likewise only applies while FIFO mode is off. The bench drives every strobe and pulse at the falling edge for exactly one rising edge, so each pulse is seen once. It changes the mode bit only through register writes, which keeps mode changes visible to the properties one cycle ahead of any effect on the flags.

// File: rtl/mbirq_pkg.sv
package mbirq_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_FLAGS = 3'd0;
  localparam logic [ADDR_W-1:0] A_BMASK = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CFG   = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd4;

  localparam int FIFO_OVF_BIT   = 7;
  localparam int FIFO_WARN_BIT  = 6;
  localparam int FIFO_AVAIL_BIT = 5;
  localparam int FIFO_LOW_W     = 5;
  localparam int FIFO_BYTE_W    = 8;

  localparam int N_STAT   = 5;
  localparam int N_CTRLM  = 4;
  localparam int CFG_W    = 2;
  localparam int CFG_FIFO = 0;
  localparam int CFG_WAKE = 1;
endpackage

// File: rtl/mbirq_flag_bank.sv
module mbirq_flag_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] zero_i,
  output logic [W-1:0] flags_o
);
  // set beats clear; forced-zero bits never receive a set
  always_ff @(posedge clk) begin
    if (rst) flags_o <= '0;
    else     flags_o <= ((flags_o & ~clr_i) | set_i) & ~zero_i;
  end
endmodule

// File: rtl/mbirq_set_map.sv
module mbirq_set_map
  import mbirq_pkg::*;
#(
  parameter int NUM_BUF = 32
) (
  input  logic               fifo_en,
  input  logic [NUM_BUF-1:0] buf_set,
  input  logic               fifo_ovf,
  input  logic               fifo_warn,
  input  logic               fifo_avail,
  output logic [NUM_BUF-1:0] set_o,
  output logic [NUM_BUF-1:0] zero_o
);
  for (genvar i = 0; i < NUM_BUF; i++) begin : g_bit
    if (i == FIFO_OVF_BIT) begin : g_ovf
      assign set_o[i]  = fifo_en ? fifo_ovf : buf_set[i];
      assign zero_o[i] = 1'b0;
    end else if (i == FIFO_WARN_BIT) begin : g_warn
      assign set_o[i]  = fifo_en ? fifo_warn : buf_set[i];
      assign zero_o[i] = 1'b0;
    end else if (i == FIFO_AVAIL_BIT) begin : g_avail
      assign set_o[i]  = fifo_en ? fifo_avail : buf_set[i];
      assign zero_o[i] = 1'b0;
    end else if (i < FIFO_LOW_W) begin : g_low
      assign set_o[i]  = fifo_en ? 1'b0 : buf_set[i];
      assign zero_o[i] = fifo_en;
    end else begin : g_plain
      assign set_o[i]  = buf_set[i];
      assign zero_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/mbirq_out.sv
module mbirq_out #(
  parameter int NUM_BUF = 32,
  parameter int N_ST    = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_BUF-1:0] flags_i,
  input  logic [NUM_BUF-1:0] mask_i,
  input  logic [N_ST-1:0]    stat_i,
  input  logic [N_ST-1:0]    stat_mask_i,
  output logic [NUM_BUF-1:0] buf_irq,
  output logic               buf_irq_any,
  output logic [N_ST-1:0]    stat_irq
);
  logic [NUM_BUF-1:0] pend;
  assign pend = flags_i & mask_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_irq     <= '0;
      buf_irq_any <= 1'b0;
      stat_irq    <= '0;
    end else begin
      buf_irq     <= pend;
      buf_irq_any <= |pend;
      stat_irq    <= stat_i & stat_mask_i;
    end
  end
endmodule

// File: rtl/mb_irq_unit.sv
module mb_irq_unit
  import mbirq_pkg::*;
#(
  parameter int NUM_BUF = 32,
  parameter int DATA_W  = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NUM_BUF-1:0]  buf_set,
  input  logic                fifo_ovf,
  input  logic                fifo_warn,
  input  logic                fifo_avail,
  input  logic                ev_busoff,
  input  logic                ev_err,
  input  logic                ev_txwarn,
  input  logic                ev_rxwarn,
  input  logic                ev_wake,
  output logic [NUM_BUF-1:0]  buf_irq,
  output logic                buf_irq_any,
  output logic [N_STAT-1:0]   stat_irq
);
  logic [NUM_BUF-1:0] bmask_q, flags_q, fset, fzero, fclr;
  logic [N_CTRLM-1:0] ctrl_q;
  logic [CFG_W-1:0]   cfg_q;
  logic [N_STAT-1:0]  stat_q, stat_set, stat_clr, stat_mask;
  logic               fifo_en;

  assign fifo_en   = cfg_q[CFG_FIFO];
  assign stat_mask = {cfg_q[CFG_WAKE], ctrl_q};
  assign stat_set  = {ev_wake, ev_rxwarn, ev_txwarn, ev_err, ev_busoff};
  assign fclr      = (reg_wr && reg_addr == A_FLAGS) ? reg_wdata[NUM_BUF-1:0] : '0;
  assign stat_clr  = (reg_wr && reg_addr == A_STAT)  ? reg_wdata[N_STAT-1:0]  : '0;

  mbirq_set_map #(.NUM_BUF(NUM_BUF)) u_map (
    .fifo_en(fifo_en), .buf_set(buf_set), .fifo_ovf(fifo_ovf),
    .fifo_warn(fifo_warn), .fifo_avail(fifo_avail),
    .set_o(fset), .zero_o(fzero)
  );

  mbirq_flag_bank #(.W(NUM_BUF)) u_bflags (
    .clk(clk), .rst(rst), .set_i(fset), .clr_i(fclr),
    .zero_i(fzero), .flags_o(flags_q)
  );

  mbirq_flag_bank #(.W(N_STAT)) u_sflags (
    .clk(clk), .rst(rst), .set_i(stat_set), .clr_i(stat_clr),
    .zero_i('0), .flags_o(stat_q)
  );

  mbirq_out #(.NUM_BUF(NUM_BUF), .N_ST(N_STAT)) u_out (
    .clk(clk), .rst(rst), .flags_i(flags_q), .mask_i(bmask_q),
    .stat_i(stat_q), .stat_mask_i(stat_mask),
    .buf_irq(buf_irq), .buf_irq_any(buf_irq_any), .stat_irq(stat_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bmask_q <= '0;
      ctrl_q  <= '0;
      cfg_q   <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_BMASK: bmask_q <= reg_wdata[NUM_BUF-1:0];
        A_CTRL:  ctrl_q  <= reg_wdata[N_CTRLM-1:0];
        A_CFG:   cfg_q   <= reg_wdata[CFG_W-1:0];
        default: ;
      endcase
    end
  end

  logic [DATA_W-1:0] rd_d;
  always_comb begin
    rd_d = '0;
    case (reg_addr)
      A_FLAGS: rd_d[NUM_BUF-1:0] = flags_q;
      A_BMASK: rd_d[NUM_BUF-1:0] = bmask_q;
      A_CTRL:  rd_d[N_CTRLM-1:0] = ctrl_q;
      A_CFG:   rd_d[CFG_W-1:0]   = cfg_q;
      A_STAT:  rd_d[N_STAT-1:0]  = stat_q;
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_d;
  end
endmodule

// File: rtl/mbirq_check.sv
module mbirq_check #(
  parameter int NUM_BUF = 32,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_wr,
  input logic [2:0]         reg_addr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic [NUM_BUF-1:0] buf_set,
  input logic               fifo_ovf,
  input logic               fifo_warn,
  input logic               fifo_avail,
  input logic               fifo_en,
  input logic [NUM_BUF-1:0] flags_q,
  input logic [4:0]         stat_q,
  input logic [NUM_BUF-1:0] buf_irq,
  input logic               buf_irq_any,
  input logic [4:0]         stat_irq
);
  p_w1c_keep_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 3'd0 && buf_set == '0 && !fifo_en &&
     !fifo_ovf && !fifo_warn && !fifo_avail)
    |=> ((flags_q & ~$past(reg_wdata[NUM_BUF-1:0])) ==
         ($past(flags_q) & ~$past(reg_wdata[NUM_BUF-1:0]))));

  p_w1c_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 3'd0 && buf_set == '0 && !fifo_en)
    |=> ((flags_q & $past(reg_wdata[NUM_BUF-1:0])) == '0));

  p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (!fifo_en && buf_set != '0) |=> ((flags_q & $past(buf_set)) == $past(buf_set)));

  p_line_needs_flag_r5: assert property (@(posedge clk) disable iff (rst)
    ((buf_irq & ~$past(flags_q)) == '0));

  p_any_matches_r6: assert property (@(posedge clk) disable iff (rst)
    (buf_irq_any == (|buf_irq)));

  p_fifo_low_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && $past(fifo_en)) |-> (flags_q[4:0] == 5'd0));

  p_stat_line_r9: assert property (@(posedge clk) disable iff (rst)
    ((stat_irq & ~$past(stat_q)) == 5'd0));
endmodule

bind mb_irq_unit mbirq_check #(.NUM_BUF(NUM_BUF), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .buf_set(buf_set), .fifo_ovf(fifo_ovf),
  .fifo_warn(fifo_warn), .fifo_avail(fifo_avail), .fifo_en(fifo_en),
  .flags_q(flags_q), .stat_q(stat_q), .buf_irq(buf_irq),
  .buf_irq_any(buf_irq_any), .stat_irq(stat_irq)
);

// File: tb/mb_irq_unit_test.sv
`timescale 1ns/1ps
module mb_irq_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic [31:0] buf_set = 32'd0;
  logic        fifo_ovf = 1'b0, fifo_warn = 1'b0, fifo_avail = 1'b0;
  logic [4:0]  ev = 5'd0;
  logic [31:0] buf_irq;
  logic        buf_irq_any;
  logic [4:0]  stat_irq;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  mb_irq_unit uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .buf_set(buf_set), .fifo_ovf(fifo_ovf), .fifo_warn(fifo_warn),
    .fifo_avail(fifo_avail), .ev_busoff(ev[0]), .ev_err(ev[1]),
    .ev_txwarn(ev[2]), .ev_rxwarn(ev[3]), .ev_wake(ev[4]),
    .buf_irq(buf_irq), .buf_irq_any(buf_irq_any), .stat_irq(stat_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 32'd0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic pulse(input logic [31:0] b, input logic [2:0] f, input logic [4:0] e);
    buf_set = b; {fifo_ovf, fifo_warn, fifo_avail} = f; ev = e;
    @(posedge clk); @(negedge clk);
    buf_set = 32'd0; {fifo_ovf, fifo_warn, fifo_avail} = 3'b000; ev = 5'd0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 buf_irq", buf_irq, 32'd0);
    check("R1 any", {31'd0, buf_irq_any}, 32'd0);
    check("R1 stat_irq", {27'd0, stat_irq}, 32'd0);
    check("R1 rdata", reg_rdata, 32'd0);
    for (int a = 0; a < 5; a++) begin
      rd(a[2:0], d);
      check("R1 reg", d, 32'd0);
    end
    rd(3'd6, d);
    check("R10 unmapped", d, 32'd0);
  endtask

  task automatic t_set_clear();
    logic [31:0] d;
    pulse(32'h0010_0008, 3'b000, 5'd0);
    rd(3'd0, d);
    check("R2 set", d, 32'h0010_0008);
    wr(3'd0, 32'h0000_0008);
    rd(3'd0, d);
    check("R3 w1c target", d, 32'h0010_0000);
    wr(3'd0, 32'h0000_0000);
    rd(3'd0, d);
    check("R3 zero write", d, 32'h0010_0000);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h0000_0200;
    buf_set = 32'h0000_0200;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 32'd0; buf_set = 32'd0;
    rd(3'd0, d);
    check("R4 set wins", d, 32'h0010_0200);
  endtask

  task automatic t_lines();
    wr(3'd1, 32'h0010_0000);
    settle();
    check("R5 line", buf_irq, 32'h0010_0000);
    check("R6 any on", {31'd0, buf_irq_any}, 32'd1);
    wr(3'd1, 32'h0000_0001);
    settle();
    check("R5 masked off", buf_irq, 32'd0);
    check("R6 any off", {31'd0, buf_irq_any}, 32'd0);
  endtask

  task automatic t_fifo();
    logic [31:0] d;
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd1, 32'd0);
    pulse(32'h0000_0004, 3'b000, 5'd0);
    wr(3'd3, 32'h0000_0001);
    pulse(32'h0000_00FF, 3'b000, 5'd0);
    rd(3'd0, d);
    check("R8 low byte ignored", d, 32'd0);
    pulse(32'd0, 3'b100, 5'd0);
    rd(3'd0, d);
    check("R7 overflow bit7", d, 32'h0000_0080);
    pulse(32'd0, 3'b011, 5'd0);
    rd(3'd0, d);
    check("R7 warn avail", d, 32'h0000_00E0);
    wr(3'd1, 32'h0000_0080);
    settle();
    check("R5 fifo line", buf_irq, 32'h0000_0080);
    wr(3'd1, 32'd0);
    wr(3'd3, 32'd0);
    wr(3'd0, 32'hFFFF_FFFF);
    pulse(32'd0, 3'b111, 5'd0);
    rd(3'd0, d);
    check("R8 fifo events off", d, 32'd0);
  endtask

  task automatic t_status();
    logic [31:0] d;
    wr(3'd2, 32'h0000_000F);
    wr(3'd3, 32'h0000_0002);
    pulse(32'd0, 3'b000, 5'h1F);
    rd(3'd4, d);
    check("R9 stat flags", d, 32'h0000_001F);
    check("R9 stat lines", {27'd0, stat_irq}, 32'h0000_001F);
    wr(3'd2, 32'h0000_000D);
    settle();
    check("R9 err masked", {27'd0, stat_irq}, 32'h0000_001D);
    wr(3'd4, 32'h0000_0012);
    rd(3'd4, d);
    check("R9 stat w1c", d, 32'h0000_000D);
    check("R6 no buf", {31'd0, buf_irq_any}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_set_clear();
    t_set_wins();
    t_lines();
    t_fifo();
    t_status();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule